// File: doc/BRIEF.md
# DRAM Command Arbiter with Activate Window

This block chooses which DRAM command leaves the controller in each cycle. Upstream logic presents two ready vectors. One holds row commands, each flagged as an activate or a precharge. The other holds column commands, each flagged as a read or a write. The arbiter returns a valid strobe and a binary index for each class. Within a class, entries take turns in round-robin order. Column commands win over row commands.

The arbiter also enforces the timing rules that span all banks. Activates must be spaced by at least `t_rrd` cycles. No more than four activates may fall inside any rolling `t_faw` window. A column command that reverses the bus direction must wait `t_turn` cycles after the previous column command. All three values are run-time inputs of 6 bits. A mode input turns on paired issue. In that mode a row command may only leave together with a column command in the same cycle. A column command may still leave alone, with the row slot empty.

Grants are combinational from the current requests and the stored timing history. The history advances on the clock edge that ends the issue cycle.

Top module: `dram_cmd_arbiter`

## Requirements
- R1: While `rst` is high, no grant is given. After reset the history counts as expired, so activates and column commands of either direction are eligible at once.
- R2: A grant only names an entry whose request bit is set in that cycle. The index is binary and is meaningful only while its valid strobe is high.
- R3: With `pair_mode`=0, at most one command issues per cycle. If any column command is eligible, one is issued and no row command is issued.
- R4: Within each class, the granted entry is the first eligible one at or after the position that follows the last grant of that class, taken cyclically. That position is 0 after reset.
- R5: An activate (`row_is_act`=1) issued in cycle c blocks further activates until cycle c+`t_rrd`.
- R6: A new activate is allowed only if the fourth most recent activate was issued at least `t_faw` cycles earlier.
- R7: A column command whose direction (`col_is_wr`=1 write, 0 read) differs from the previous column command is allowed only `t_turn` or more cycles after that command. Same-direction column commands are not delayed.
- R8: With `pair_mode`=1, a row command issues only in a cycle in which a column command also issues. When both classes are eligible, both issue in that cycle.
- R9: With `pair_mode`=1 and no eligible row command, an eligible column command issues alone.
- R10: Precharges (`row_is_act`=0) are never held by `t_rrd` or `t_faw`. An activate held by those limits does not stop a ready precharge from issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_mode | input | 1 | 1: paired row+column issue, 0: single issue |
| t_faw | input | 6 | Four-activate window length in cycles |
| t_rrd | input | 6 | Minimum activate-to-activate spacing in cycles |
| t_turn | input | 6 | Read/write direction change gap in cycles |
| row_req | input | N_ROW | Ready bits of the row command entries |
| row_is_act | input | N_ROW | Per row entry: 1 activate, 0 precharge |
| col_req | input | N_COL | Ready bits of the column command entries |
| col_is_wr | input | N_COL | Per column entry: 1 write, 0 read |
| row_vld | output | 1 | A row command issues this cycle |
| row_idx | output | clog2(N_ROW) | Index of the issued row entry |
| col_vld | output | 1 | A column command issues this cycle |
| col_idx | output | clog2(N_COL) | Index of the issued column entry |

## Verification
Random mixes of row and column requests in single-issue mode, with all timing values at zero, separate the priority rule from the round-robin pointers. Row-only traffic that mixes activates and precharges under nonzero `t_rrd` and `t_faw` shows whether held activates wrongly block precharges. A saturating stream of activates with `t_rrd`=1 and `t_faw`=10 must produce exactly eight activates in fourteen cycles, which catches an off-by-one in the window. Column-only traffic with random directions isolates the turnaround gap. Paired-mode runs, with and without row requests, separate the column-alone case from the forbidden row-alone case.

// File: rtl/dca_pkg.sv
package dca_pkg;
    localparam int TICK_W    = 6;
    localparam int FAW_DEPTH = 4;

    typedef logic [TICK_W-1:0] tick_t;
    localparam tick_t TICK_MAX = '1;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } col_dir_e;

    function automatic tick_t tick_inc(tick_t t);
        return (t == TICK_MAX) ? t : t + 1'b1;
    endfunction

    function automatic int idx_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/dca_rr_pick.sv
module dca_rr_pick
    import dca_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = idx_w(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          vld,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] ptr;

    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = int'(ptr) + i;
            if (j >= N) j = j - N;
            if (!vld && req[j]) begin
                vld = 1'b1;
                idx = IW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (take) begin
            ptr <= (int'(idx) == N - 1) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/dca_act_window.sv
module dca_act_window
    import dca_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tick_t t_faw,
    input  tick_t t_rrd,
    input  logic  act_fire,
    output logic  act_ok
);
    tick_t age [FAW_DEPTH];

    assign act_ok = (age[0] >= t_rrd) && (age[FAW_DEPTH-1] >= t_faw);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FAW_DEPTH; i++) age[i] <= TICK_MAX;
        end else if (act_fire) begin
            age[0] <= tick_t'(1);
            for (int i = 1; i < FAW_DEPTH; i++) age[i] <= tick_inc(age[i-1]);
        end else begin
            for (int i = 0; i < FAW_DEPTH; i++) age[i] <= tick_inc(age[i]);
        end
    end
endmodule

// File: rtl/dca_turn_guard.sv
module dca_turn_guard
    import dca_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tick_t    t_turn,
    input  logic     col_fire,
    input  col_dir_e col_dir,
    output logic     rd_ok,
    output logic     wr_ok
);
    tick_t    since;
    col_dir_e last;

    assign rd_ok = (last == DIR_RD) || (since >= t_turn);
    assign wr_ok = (last == DIR_WR) || (since >= t_turn);

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= TICK_MAX;
            last  <= DIR_RD;
        end else if (col_fire) begin
            since <= tick_t'(1);
            last  <= col_dir;
        end else begin
            since <= tick_inc(since);
        end
    end
endmodule

// File: rtl/dram_cmd_arbiter.sv
module dram_cmd_arbiter
    import dca_pkg::*;
#(
    parameter int N_ROW = 4,
    parameter int N_COL = 4,
    localparam int RIW  = idx_w(N_ROW),
    localparam int CIW  = idx_w(N_COL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pair_mode,
    input  logic [TICK_W-1:0] t_faw,
    input  logic [TICK_W-1:0] t_rrd,
    input  logic [TICK_W-1:0] t_turn,
    input  logic [N_ROW-1:0] row_req,
    input  logic [N_ROW-1:0] row_is_act,
    input  logic [N_COL-1:0] col_req,
    input  logic [N_COL-1:0] col_is_wr,
    output logic             row_vld,
    output logic [RIW-1:0]   row_idx,
    output logic             col_vld,
    output logic [CIW-1:0]   col_idx
);
    logic act_ok, rd_ok, wr_ok;
    logic [N_ROW-1:0] row_elig;
    logic [N_COL-1:0] col_elig;
    logic row_cand, col_cand;
    logic act_fire;
    col_dir_e col_dir;

    for (genvar r = 0; r < N_ROW; r++) begin : g_row_elig
        assign row_elig[r] = row_req[r] && !rst && (!row_is_act[r] || act_ok);
    end

    for (genvar c = 0; c < N_COL; c++) begin : g_col_elig
        assign col_elig[c] = col_req[c] && !rst && (col_is_wr[c] ? wr_ok : rd_ok);
    end

    dca_rr_pick #(.N(N_ROW), .IW(RIW)) u_row_pick (
        .clk  (clk),
        .rst  (rst),
        .req  (row_elig),
        .take (row_vld),
        .vld  (row_cand),
        .idx  (row_idx)
    );

    dca_rr_pick #(.N(N_COL), .IW(CIW)) u_col_pick (
        .clk  (clk),
        .rst  (rst),
        .req  (col_elig),
        .take (col_vld),
        .vld  (col_cand),
        .idx  (col_idx)
    );

    assign col_vld  = col_cand;
    assign row_vld  = pair_mode ? (row_cand && col_cand) : (row_cand && !col_cand);
    assign act_fire = row_vld && row_is_act[row_idx];
    assign col_dir  = col_is_wr[col_idx] ? DIR_WR : DIR_RD;

    dca_act_window u_act_win (
        .clk      (clk),
        .rst      (rst),
        .t_faw    (t_faw),
        .t_rrd    (t_rrd),
        .act_fire (act_fire),
        .act_ok   (act_ok)
    );

    dca_turn_guard u_turn (
        .clk      (clk),
        .rst      (rst),
        .t_turn   (t_turn),
        .col_fire (col_vld),
        .col_dir  (col_dir),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok)
    );
endmodule

// File: rtl/dram_cmd_arbiter_chk.sv
module dram_cmd_arbiter_chk
    import dca_pkg::*;
#(
    parameter int N_ROW = 4,
    parameter int N_COL = 4,
    localparam int RIW  = idx_w(N_ROW),
    localparam int CIW  = idx_w(N_COL)
) (
    input logic             clk,
    input logic             rst,
    input logic             pair_mode,
    input logic [TICK_W-1:0] t_faw,
    input logic [TICK_W-1:0] t_rrd,
    input logic [TICK_W-1:0] t_turn,
    input logic [N_ROW-1:0] row_req,
    input logic [N_ROW-1:0] row_is_act,
    input logic [N_COL-1:0] col_req,
    input logic [N_COL-1:0] col_is_wr,
    input logic             row_vld,
    input logic [RIW-1:0]   row_idx,
    input logic             col_vld,
    input logic [CIW-1:0]   col_idx
);
    tick_t gap_act, gap_col;
    logic  prev_wr;
    logic  is_act, is_wr;

    assign is_act = row_vld && row_is_act[row_idx];
    assign is_wr  = col_is_wr[col_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_act <= TICK_MAX;
            gap_col <= TICK_MAX;
            prev_wr <= 1'b0;
        end else begin
            gap_act <= is_act ? tick_t'(1) : tick_inc(gap_act);
            gap_col <= col_vld ? tick_t'(1) : tick_inc(gap_col);
            if (col_vld) prev_wr <= is_wr;
        end
    end

    // R1
    no_grant_in_reset_chk: assert property (@(posedge clk) rst |-> (!row_vld && !col_vld));

    // R2
    row_grant_requested_chk: assert property (@(posedge clk) disable iff (rst)
        row_vld |-> row_req[row_idx]);

    // R2
    col_grant_requested_chk: assert property (@(posedge clk) disable iff (rst)
        col_vld |-> col_req[col_idx]);

    // R3
    single_issue_chk: assert property (@(posedge clk) disable iff (rst)
        !pair_mode |-> !(row_vld && col_vld));

    // R8
    row_needs_col_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_mode && row_vld) |-> col_vld);

    // R5
    act_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (gap_act >= t_rrd));

    // R7
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (col_vld && (is_wr != prev_wr)) |-> (gap_col >= t_turn));
endmodule

bind dram_cmd_arbiter dram_cmd_arbiter_chk #(.N_ROW(N_ROW), .N_COL(N_COL)) u_chk (.*);

// File: tb/dram_cmd_arbiter_tb.sv
`timescale 1ns/1ps
module dram_cmd_arbiter_tb;
    localparam int NR = 4;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pair_mode = 1'b0;
    logic [5:0] t_faw = '0, t_rrd = '0, t_turn = '0;
    logic [NR-1:0] row_req = '0, row_is_act = '0;
    logic [NC-1:0] col_req = '0, col_is_wr = '0;
    logic row_vld, col_vld;
    logic [1:0] row_idx, col_idx;

    always #2 clk = ~clk;

    dram_cmd_arbiter #(.N_ROW(NR), .N_COL(NC)) u_dut (
        .clk(clk), .rst(rst), .pair_mode(pair_mode),
        .t_faw(t_faw), .t_rrd(t_rrd), .t_turn(t_turn),
        .row_req(row_req), .row_is_act(row_is_act),
        .col_req(col_req), .col_is_wr(col_is_wr),
        .row_vld(row_vld), .row_idx(row_idx),
        .col_vld(col_vld), .col_idx(col_idx)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int act_q[$];
    int cyc;
    int rptr, cptr;
    bit have_col;
    int last_col_t;
    bit last_wr;
    int act_seen;

    task automatic model_reset();
        act_q.delete();
        cyc = 0; rptr = 0; cptr = 0;
        have_col = 0; last_col_t = 0; last_wr = 0;
    endtask

    function automatic void pick(input logic [3:0] req, input int ptr, input int n,
                                 output bit found, output int idx);
        found = 0; idx = 0;
        for (int i = 0; i < n; i++) begin
            int j = (ptr + i) % n;
            if (!found && req[j]) begin found = 1; idx = j; end
        end
    endfunction

    // evaluate one cycle: compare and advance model; inputs already stable
    task automatic step(input string tag);
        bit act_ok, rf, cf, er, ec;
        int ri, ci, n;
        logic [3:0] re, ce;
        #1;
        n = act_q.size();
        act_ok = (n == 0 || cyc - act_q[n-1] >= int'(t_rrd)) &&
                 (n < 4 || cyc - act_q[n-4] >= int'(t_faw));
        for (int i = 0; i < NR; i++) re[i] = row_req[i] && (!row_is_act[i] || act_ok);
        for (int i = 0; i < NC; i++)
            ce[i] = col_req[i] && (!have_col || (col_is_wr[i] == last_wr) ||
                                   (cyc - last_col_t >= int'(t_turn)));
        pick(re, rptr, NR, rf, ri);
        pick(ce, cptr, NC, cf, ci);
        ec = cf;
        er = pair_mode ? (rf && cf) : (rf && !cf);
        checks++;
        if (row_vld !== er || col_vld !== ec ||
            (er && int'(row_idx) != ri) || (ec && int'(col_idx) != ci)) begin
            errors++;
            $display("FAIL %s cyc %0d: got row %0b/%0d col %0b/%0d, expected row %0b/%0d col %0b/%0d",
                     tag, cyc, row_vld, row_idx, col_vld, col_idx, er, ri, ec, ci);
        end
        if (row_vld && row_is_act[row_idx]) act_seen++;
        if (er) begin
            if (row_is_act[ri]) begin
                act_q.push_back(cyc);
                if (act_q.size() > 4) void'(act_q.pop_front());
            end
            rptr = (ri + 1) % NR;
        end
        if (ec) begin
            have_col = 1; last_col_t = cyc; last_wr = col_is_wr[ci];
            cptr = (ci + 1) % NC;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        row_req = '0; col_req = '0;
        for (int i = 0; i < n; i++) step("idle R1");
    endtask

    initial begin
        model_reset();
        row_req = '1; row_is_act = '1; col_req = '1;
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (row_vld !== 1'b0 || col_vld !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got row %0b col %0b, expected 0 0", row_vld, col_vld);
        end
        row_req = '0; col_req = '0;
        @(negedge clk);
        rst = 1'b0;

        // R1: first activate and a write both allowed at once
        t_faw = 6'd20; t_rrd = 6'd5; t_turn = 6'd9;
        row_req = 4'b0100; row_is_act = '1;
        step("R1 first act");
        row_req = '0; col_req = 4'b0010; col_is_wr = '1;
        step("R1 first write");
        idle(70);

        // R2 R3 R4: single mode, precharges only, no timing
        t_faw = 0; t_rrd = 0; t_turn = 0;
        for (int k = 0; k < 300; k++) begin
            row_req = 4'($urandom); row_is_act = '0;
            col_req = 4'($urandom) & 4'($urandom); col_is_wr = 4'($urandom);
            step("R2 R3 R4 prio/rr");
        end
        idle(70);

        // R5 R6 R10: rows only, mixed types
        t_rrd = 6'd3; t_faw = 6'd12;
        for (int k = 0; k < 400; k++) begin
            row_req = 4'($urandom); row_is_act = 4'($urandom) | 4'($urandom);
            col_req = '0;
            step("R5 R6 R10 act timing");
        end
        idle(70);

        // R6: saturated activate stream, 8 activates expected in 14 cycles
        t_rrd = 6'd1; t_faw = 6'd10;
        act_seen = 0;
        row_req = '1; row_is_act = '1;
        for (int k = 0; k < 14; k++) step("R6 window");
        checks++;
        if (act_seen != 8) begin
            errors++;
            $display("FAIL R6 window count: got %0d, expected 8", act_seen);
        end
        idle(70);

        // R7: columns only with direction changes
        t_turn = 6'd5;
        for (int k = 0; k < 400; k++) begin
            row_req = '0; col_req = 4'($urandom); col_is_wr = 4'($urandom);
            step("R7 turnaround");
        end
        idle(70);

        // R8 R9: paired mode
        pair_mode = 1'b1;
        t_rrd = 6'd2; t_faw = 6'd9; t_turn = 6'd3;
        for (int k = 0; k < 500; k++) begin
            row_req = 4'($urandom); row_is_act = 4'($urandom);
            col_req = (k % 5 == 0) ? 4'b0000 : 4'($urandom);
            col_is_wr = 4'($urandom);
            if (k % 7 == 0) row_req = '0;
            step("R8 R9 paired");
        end

        // mixed: random timing and modes
        for (int k = 0; k < 1000; k++) begin
            if (k % 50 == 0) begin
                t_rrd = 6'($urandom_range(0, 6)); t_faw = 6'($urandom_range(0, 30));
                t_turn = 6'($urandom_range(0, 8)); pair_mode = 1'($urandom);
            end
            row_req = 4'($urandom); row_is_act = 4'($urandom);
            col_req = 4'($urandom) & 4'($urandom); col_is_wr = 4'($urandom);
            step("R2 R3 R5 R6 R7 R8 R9 mixed");
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule